// File: doc/BRIEF.md
# Windowed Bank Mapper for an 8-bit CPU

This block widens a 16-bit CPU address into a 19-bit SRAM address. The CPU's 64 KB space is cut into eight windows of 8 KB. Each window has its own 6-bit bank register. On every access, the top three CPU address bits pick that window's register. The register's value becomes the upper six bits of the physical address, and the CPU's low 13 bits pass through unchanged as the offset. Any of 64 physical 8 KB banks can therefore appear in any window, and each window is set independently.

Software programs the registers through eight consecutive I/O locations. The surrounding decoder raises a register-select strobe for those locations, and the low three address bits name the register. A write becomes final on the falling edge of the CPU's phase-2 clock. The same locations read back the current register value. The block also drives the SRAM output-enable and write-enable strobes from the read/write line, the phase-2 clock and a RAM-select input that the surrounding decoder provides. All logic runs on a fast system clock, and phase-2 is sampled as an ordinary input.

Top module: `mmu_window_mapper`

## Requirements
- R1: After reset, register n holds n, so every CPU address maps to the same value in the physical space (sram_addr = {3'b000, cpu_addr}).
- R2: sram_addr[18:13] equals the bank register selected by cpu_addr[15:13].
- R3: sram_addr[12:0] equals cpu_addr[12:0] in every cycle.
- R4: A write cycle (reg_sel = 1, rwb = 0) loads data_in[5:0] into the register numbered cpu_addr[2:0]. The load takes the values held in the last system-clock cycle in which phi2 was high, and it happens when phi2 falls. data_in[7:6] are discarded.
- R5: While phi2 is high, if reg_sel is 0 or rwb is 1, a following phi2 fall changes no register.
- R6: While reg_sel = 1 and rwb = 1, data_out equals {2'b00, register[cpu_addr[2:0]]}. Otherwise data_out is 8'h00.
- R7: sram_oe_n is low exactly when ram_sel, rwb and phi2 are all 1.
- R8: sram_we_n is low exactly when ram_sel = 1, rwb = 0 and phi2 = 1. It is never low while phi2 is low.
- R9: sram_oe_n and sram_we_n are never low at the same time.
- R10: A register write has no effect on sram_addr or data_out before the system-clock edge that samples phi2 low. The new value appears in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; phi2 is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | CPU phase-2 clock, sampled as data |
| rwb | input | 1 | CPU read (1) / write (0) line |
| ram_sel | input | 1 | External decode: the current access targets RAM |
| reg_sel | input | 1 | External decode: the current access targets the bank registers |
| cpu_addr | input | 16 | CPU address bus |
| data_in | input | 8 | CPU write data |
| data_out | output | 8 | Register read-back data |
| sram_addr | output | 19 | Physical SRAM address |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |

## Verification
The assertions assume that phi2, rwb, the selects, the address and the data all change in step with the system clock. They also assume that each phi2 level lasts at least one system-clock cycle, and that the address and write data of a register write stay unchanged from the last high cycle through the cycle in which phi2 is low. The bench drives every input one time unit after a rising edge. It keeps the address and data of each register write in place across the high step and the following low step. It compares outputs half a period later, against a model of the registers that commits a write only once a high step is followed by a low step.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
    localparam int unsigned DEF_WIN_BITS = 3;
    localparam int unsigned DEF_BANK_W   = 6;
    localparam int unsigned DEF_OFF_W    = 13;
    localparam int unsigned DEF_DATA_W   = 8;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/bank_sel_mux.sv
module bank_sel_mux #(
    parameter int unsigned WIN_BITS = 3,
    parameter int unsigned BANK_W   = 6,
    localparam int unsigned NWIN    = 1 << WIN_BITS
) (
    input  logic [NWIN-1:0][BANK_W-1:0] bank,
    input  logic [WIN_BITS-1:0]         sel,
    output logic [BANK_W-1:0]           q
);
    logic [NWIN-1:0] hit;

    for (genvar n = 0; n < NWIN; n++) begin : g_hit
        assign hit[n] = (sel == WIN_BITS'(n));
    end

    always_comb begin
        q = '0;
        for (int n = 0; n < NWIN; n++) begin
            q = q | (bank[n] & {BANK_W{hit[n]}});
        end
    end
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile #(
    parameter int unsigned WIN_BITS = 3,
    parameter int unsigned BANK_W   = 6,
    localparam int unsigned NWIN    = 1 << WIN_BITS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        phi2,
    input  logic                        rwb,
    input  logic                        reg_sel,
    input  logic [WIN_BITS-1:0]         idx,
    input  logic [BANK_W-1:0]           wdata,
    output logic [NWIN-1:0][BANK_W-1:0] bank
);
    typedef struct packed {
        logic                        phi2;
        logic                        pend;
        logic [WIN_BITS-1:0]         idx;
        logic [BANK_W-1:0]           data;
        logic [NWIN-1:0][BANK_W-1:0] bank;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.phi2 = phi2;
        if (st_q.phi2 && !phi2 && st_q.pend) begin
            st_d.bank[st_q.idx] = st_q.data;
        end
        if (phi2) begin
            st_d.pend = reg_sel && !rwb;
            st_d.idx  = idx;
            st_d.data = wdata;
        end else begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int n = 0; n < NWIN; n++) begin
                st_q.bank[n] <= BANK_W'(n);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign bank = st_q.bank;

    for (genvar i = 0; i < NWIN; i++) begin : g_chk
        p_bank_moves_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(bank[i]) |-> ($past(st_q.phi2) && !$past(phi2) && $past(st_q.pend)));
    end
endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen
    import mmu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic phi2,
    input  logic rwb,
    input  logic ram_sel,
    output logic sram_oe_n,
    output logic sram_we_n
);
    acc_kind_e kind;

    always_comb begin
        if (!ram_sel || !phi2) begin
            kind = ACC_IDLE;
        end else if (rwb) begin
            kind = ACC_READ;
        end else begin
            kind = ACC_WRITE;
        end
    end

    assign sram_oe_n = (kind != ACC_READ);
    assign sram_we_n = (kind != ACC_WRITE);

    p_we_only_in_phi2_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (phi2 && !rwb));
    p_oe_only_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (phi2 && rwb));
    p_strobes_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_oe_n && !sram_we_n));
endmodule

// File: rtl/mmu_window_mapper.sv
module mmu_window_mapper
    import mmu_pkg::*;
#(
    parameter int unsigned WIN_BITS = DEF_WIN_BITS,
    parameter int unsigned BANK_W   = DEF_BANK_W,
    parameter int unsigned OFF_W    = DEF_OFF_W,
    parameter int unsigned DATA_W   = DEF_DATA_W,
    localparam int unsigned NWIN    = 1 << WIN_BITS,
    localparam int unsigned CPU_AW  = WIN_BITS + OFF_W,
    localparam int unsigned PHYS_AW = BANK_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               phi2,
    input  logic               rwb,
    input  logic               ram_sel,
    input  logic               reg_sel,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  data_in,
    output logic [DATA_W-1:0]  data_out,
    output logic [PHYS_AW-1:0] sram_addr,
    output logic               sram_oe_n,
    output logic               sram_we_n
);
    logic [NWIN-1:0][BANK_W-1:0] bank;
    logic [BANK_W-1:0]           win_bank;
    logic [BANK_W-1:0]           rb_bank;
    logic                        unused_data_hi;

    assign unused_data_hi = ^data_in[DATA_W-1:BANK_W];

    bank_regfile #(.WIN_BITS(WIN_BITS), .BANK_W(BANK_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .phi2    (phi2),
        .rwb     (rwb),
        .reg_sel (reg_sel),
        .idx     (cpu_addr[WIN_BITS-1:0]),
        .wdata   (data_in[BANK_W-1:0]),
        .bank    (bank)
    );

    bank_sel_mux #(.WIN_BITS(WIN_BITS), .BANK_W(BANK_W)) u_win_mux (
        .bank (bank),
        .sel  (cpu_addr[CPU_AW-1:OFF_W]),
        .q    (win_bank)
    );

    bank_sel_mux #(.WIN_BITS(WIN_BITS), .BANK_W(BANK_W)) u_rb_mux (
        .bank (bank),
        .sel  (cpu_addr[WIN_BITS-1:0]),
        .q    (rb_bank)
    );

    sram_strobe_gen u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .phi2      (phi2),
        .rwb       (rwb),
        .ram_sel   (ram_sel),
        .sram_oe_n (sram_oe_n),
        .sram_we_n (sram_we_n)
    );

    assign sram_addr = {win_bank, cpu_addr[OFF_W-1:0]};
    assign data_out  = (reg_sel && rwb) ? DATA_W'(rb_bank) : '0;

    p_map_hold_in_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(cpu_addr) && $past(phi2)) |-> $stable(sram_addr));
endmodule

// File: tb/mmu_window_mapper_tb_top.sv
`timescale 1ns/1ps
module mmu_window_mapper_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phi2 = 1'b0, rwb = 1'b1, ram_sel = 1'b0, reg_sel = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  data_in = '0;
    logic [7:0]  data_out;
    logic [18:0] sram_addr;
    logic        sram_oe_n, sram_we_n;

    always #5 clk = ~clk;

    mmu_window_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .phi2(phi2), .rwb(rwb), .ram_sel(ram_sel),
        .reg_sel(reg_sel), .cpu_addr(cpu_addr), .data_in(data_in),
        .data_out(data_out), .sram_addr(sram_addr),
        .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
    );

    typedef struct {
        logic [18:0] addr;
        logic [7:0]  dout;
        logic        oe_n;
        logic        we_n;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    exp_t        cur;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    logic [5:0]  bm [8];
    bit          prev_phi2 = 1'b0;
    bit          pend = 1'b0;
    logic [2:0]  pidx = '0;
    logic [5:0]  pdata = '0;

    // Monitor: compares half a period after the driver changes inputs.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            cur = sb_q.pop_front();
            checks++;
            if (sram_addr !== cur.addr || data_out !== cur.dout ||
                sram_oe_n !== cur.oe_n || sram_we_n !== cur.we_n) begin
                errors++;
                $display("FAIL %s: got addr=%h dout=%h oe_n=%b we_n=%b, expected addr=%h dout=%h oe_n=%b we_n=%b",
                         cur.tag, sram_addr, data_out, sram_oe_n, sram_we_n,
                         cur.addr, cur.dout, cur.oe_n, cur.we_n);
            end
        end
    end

    // Driver: one system-clock cycle per call; pushes the expected outputs.
    task automatic step(input bit p, input bit rw, input bit rs, input bit gs,
                        input logic [15:0] a, input logic [7:0] d, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        phi2 = p; rwb = rw; ram_sel = rs; reg_sel = gs; cpu_addr = a; data_in = d;
        e.addr = {bm[a[15:13]], a[12:0]};
        e.dout = (gs && rw) ? {2'b00, bm[a[2:0]]} : 8'h00;
        e.oe_n = !(rs && rw && p);
        e.we_n = !(rs && !rw && p);
        e.tag  = tag;
        sb_q.push_back(e);
        if (prev_phi2 && !p && pend) bm[pidx] = pdata;
        if (p) begin
            pend  = gs && !rw;
            pidx  = a[2:0];
            pdata = d[5:0];
        end else begin
            pend = 1'b0;
        end
        prev_phi2 = p;
    endtask

    task automatic wr_reg(input logic [15:0] a, input logic [7:0] d, input string tag);
        step(1'b1, 1'b0, 1'b0, 1'b1, a, d, tag);
        step(1'b0, 1'b0, 1'b0, 1'b1, a, d, {tag, " R10 old value at fall"});
    endtask

    task automatic rd_reg(input logic [2:0] i, input string tag);
        step(1'b1, 1'b1, 1'b0, 1'b1, {13'h1F00, i}, 8'h00, tag);
    endtask

    initial begin
        for (int n = 0; n < 8; n++) bm[n] = 6'(n);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 / R3 / R7: identity map after reset, RAM read strobes
        for (int w = 0; w < 8; w++) begin
            step(1'b1, 1'b1, 1'b1, 1'b0, {3'(w), 13'h0155}, 8'h00, "R1 R3 R7 reset identity");
        end
        // R6: reset read-back
        for (int i = 0; i < 8; i++) rd_reg(3'(i), "R6 reset read-back");
        step(1'b1, 1'b1, 1'b0, 1'b0, 16'h0003, 8'h00, "R6 no select gives zero");

        // R4: write with upper data bits set; R10 checked in the low step
        wr_reg(16'hFE03, 8'hEA, "R4 write reg3");
        rd_reg(3'd3, "R4 upper bits dropped");
        step(1'b1, 1'b1, 1'b1, 1'b0, 16'h6ABC, 8'h00, "R2 window3 remapped");

        // R5: a read of the register location, then a RAM write, change nothing
        step(1'b1, 1'b1, 1'b0, 1'b1, 16'h0005, 8'h3F, "R5 read cycle on reg5");
        step(1'b0, 1'b1, 1'b0, 1'b1, 16'h0005, 8'h3F, "R5 fall after read");
        rd_reg(3'd5, "R5 reg5 unchanged");
        step(1'b1, 1'b0, 1'b1, 1'b0, 16'h2005, 8'h11, "R8 R9 RAM write strobe");
        step(1'b0, 1'b0, 1'b1, 1'b0, 16'h2005, 8'h11, "R8 no write strobe with phi2 low");
        rd_reg(3'd5, "R5 reg5 unchanged after RAM write");

        // R4: phi2 held high several cycles, the last value wins
        step(1'b1, 1'b0, 1'b0, 1'b1, 16'h0001, 8'h0B, "R4 first high cycle");
        step(1'b1, 1'b0, 1'b0, 1'b1, 16'h0001, 8'h16, "R10 still old in long high");
        step(1'b0, 1'b0, 1'b0, 1'b1, 16'h0001, 8'h16, "R10 old at fall");
        rd_reg(3'd1, "R4 last high value kept");

        // R2: load all eight registers, then sweep the windows
        for (int i = 0; i < 8; i++) begin
            wr_reg({13'h0100, 3'(i)}, 8'((i * 23 + 9) % 64), "R4 load all");
        end
        for (int w = 0; w < 8; w++) begin
            step(1'b1, 1'b1, 1'b1, 1'b0, {3'(w), 13'(w * 1031 + 7)}, 8'h00, "R2 R3 window sweep");
        end
        for (int w = 0; w < 8; w++) begin
            step(1'b0, 1'b1, 1'b1, 1'b0, {3'(7 - w), 13'h1FFF}, 8'h00, "R2 R7 sweep phi2 low");
        end
        for (int i = 0; i < 8; i++) rd_reg(3'(i), "R6 read-back after load");

        @(posedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule